// File: doc/BRIEF.md
# SECDED Write Path with Fault Injection

This block sits on the write side of a 64-bit memory that keeps 8 check bits per beat. On each write beat it merges the new bytes into the old contents, encodes a single-error-correct, double-error-detect Hamming code over the merged data, and can then corrupt chosen data bits or check bits on purpose. The corrupted word can be stored, read back and handed to the read-side checker, so that its correction and detection paths can be tested. It registers one 72-bit word to store per write beat.

A beat with some byte enables clear is treated as a read-modify-write. The caller supplies the current (already corrected) contents of the location, and the enabled bytes of the new data replace the matching old bytes. The merged word is then encoded and goes through the same injection stage as a full write. With injection disabled and mirroring off, a full write stores a clean code and so repairs a location that was corrupted earlier. A combinational SECDED decoder for the stored format is included alongside. It lets a bench or a neighbouring read path confirm that corrupted words are reported and corrected as intended.

Top module: `ecc_inject_wpath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `st_valid` becomes 0 and `st_word` becomes all zeros. Both stay so until the first write beat after reset.
- R2: A beat presented with `wr_valid` high appears on `st_word` with `st_valid` high after exactly one rising edge. After an edge with `wr_valid` low, `st_valid` is 0 and `st_word` keeps its previous value.
- R3: The stored word is laid out as {check[7:0], data[63:0]}. Hamming positions run from 1 to 71. Check bit k (k = 0..6) sits at position 2^k. Data bit i sits at the (i+1)-th position in 1..71 that is not a power of two, so data bit 0 is at position 3 and data bit 63 is at position 71. Check bit k is the XOR of every data bit whose position has bit k set. Check bit 7 gives the whole 72-bit word even parity.
- R4: For each byte b in 0..7, merged byte b is taken from `wr_data` when `wr_be[b]` is 1 and from `rd_merge_data` when it is 0. All later steps act on the merged word.
- R5: With `cfg_inj_en` = 0 and `cfg_mirror_en` = 0, the stored data equals the merged data and the stored check byte equals its clean code. The mask inputs then have no effect.
- R6: With `cfg_inj_en` = 1, the stored data equals the merged data XOR {`cfg_mask_hi`, `cfg_mask_lo`}. `cfg_mask_hi` covers data bits 63:32.
- R7: With `cfg_inj_en` = 1 and `cfg_mirror_en` = 0, the stored check byte equals `cfg_chk_mask` XOR the code of the uncorrupted merged data. Any value 0x00..0xFF is accepted.
- R8: With `cfg_mirror_en` = 1, the stored check byte equals stored data bits 7:0 after any data injection, whatever `cfg_inj_en` is. `cfg_chk_mask` then has no effect.
- R9: The decoder forms `dec_syndrome` = {p, s}. Here p is the XOR of all 72 bits of `dec_word`, and s is the XOR of the positions (per R3) of all set bits. Status encodings are 2'b00 clean, 2'b01 corrected and 2'b10 uncorrectable. When p = 0 and s = 0, the status is clean and `dec_data` equals the received data.
- R10: When p = 1 and s is 0, a power of two, or a data position, the status is corrected. If s names a data bit, that bit is flipped in `dec_data`; otherwise `dec_data` equals the received data.
- R11: The status is uncorrectable, and `dec_data` equals the received data, in two cases: p = 0 with s ≠ 0, or p = 1 with s above 71.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write beat present this cycle |
| wr_data | input | 64 | New write data |
| wr_be | input | 8 | Byte enables for the new data |
| rd_merge_data | input | 64 | Current location contents for partial writes |
| cfg_mask_hi | input | 32 | Flip mask for data bits 63:32 |
| cfg_mask_lo | input | 32 | Flip mask for data bits 31:0 |
| cfg_chk_mask | input | 8 | Flip mask for the check byte |
| cfg_inj_en | input | 1 | Enables both flip masks |
| cfg_mirror_en | input | 1 | Replaces the check byte with stored data byte 0 |
| st_valid | output | 1 | Stored word valid |
| st_word | output | 72 | Word to store, {check, data} |
| dec_word | input | 72 | Word read back, for the decoder |
| dec_data | output | 64 | Corrected read data |
| dec_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| dec_syndrome | output | 8 | {overall parity, 7-bit position syndrome} |

## Verification
Two functions can act on one beat: the byte merge and the fault injection. The bench provokes this with partial beats sent while injection is armed, including masks that hit both enabled and merged bytes. It judges the result against a reference that merges first, encodes the clean merged data and only then flips bits. A second pairing puts mirroring together with an armed check mask. There the bench expects the mirrored byte to carry the injected data flips and the check mask to leave no trace.

// File: rtl/ecc_inj_pkg.sv
// Package ecc_inj_pkg
// Shared widths, decoder status codes and the Hamming position map used by
// the SECDED write path and its read-side decoder.
// Assumes a 64-bit data beat with 7 Hamming bits plus one overall parity bit.
package ecc_inj_pkg;

    localparam int DATA_W  = 64;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = DATA_W / BYTE_W;
    localparam int HAM_W   = 7;
    localparam int CHK_W   = HAM_W + 1;
    localparam int WORD_W  = DATA_W + CHK_W;
    localparam int HALF_W  = DATA_W / 2;
    localparam int MAX_POS = DATA_W + HAM_W;

    typedef enum logic [1:0] {
        DEC_CLEAN = 2'b00,
        DEC_FIXED = 2'b01,
        DEC_FATAL = 2'b10
    } dec_status_e;

    // Hamming position of data bit idx: the (idx+1)-th non power of two from 1
    function automatic logic [HAM_W-1:0] data_pos(input int idx);
        int cnt;
        logic [HAM_W-1:0] res;
        cnt = 0;
        res = '0;
        for (int p = 1; p < (1 << HAM_W); p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) res = p[HAM_W-1:0];
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/eccw_merge.sv
// Module eccw_merge
// Byte-lane merge for sub-beat writes: each lane takes the new data when its
// enable is set and the current contents otherwise.
// Assumes rd_merge_data is already corrected by the read path.
module eccw_merge
    import ecc_inj_pkg::*;
#(
    parameter int LANES  = NBYTES,
    parameter int LANE_W = BYTE_W
) (
    input  logic [LANES*LANE_W-1:0] new_data,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] old_data,
    output logic [LANES*LANE_W-1:0] merged
);

    // One multiplexer per byte lane
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[b*LANE_W +: LANE_W] = lane_en[b] ? new_data[b*LANE_W +: LANE_W]
                                                       : old_data[b*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/eccw_encode.sv
// Module eccw_encode
// SECDED encoder: seven Hamming bits over the data at their mapped positions,
// plus an eighth bit giving the full data+check word even parity.
// Assumes the input data is uncorrupted (injection happens downstream).
module eccw_encode
    import ecc_inj_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);

    logic [HAM_W-1:0] ham;

    // Accumulate the position of every set data bit into the Hamming bits
    always_comb begin
        ham = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data[i]) ham = ham ^ data_pos(i);
        end
    end

    // Overall parity closes the word to even parity
    assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/eccw_inject.sv
// Module eccw_inject
// Fault injection stage: XORs the data and check masks under a global enable,
// then optionally replaces the check byte with the final data byte 0.
// Assumes the check byte was computed from the clean data.
module eccw_inject
    import ecc_inj_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  chk_in,
    input  logic [HALF_W-1:0] mask_hi,
    input  logic [HALF_W-1:0] mask_lo,
    input  logic [CHK_W-1:0]  mask_chk,
    input  logic              inj_en,
    input  logic              mirror_en,
    output logic [DATA_W-1:0] data_out,
    output logic [CHK_W-1:0]  chk_out
);

    logic [CHK_W-1:0] chk_flip;

    // Apply the data mask only while injection is armed
    always_comb begin
        data_out = inj_en ? (data_in ^ {mask_hi, mask_lo}) : data_in;
    end

    // Apply the check mask, then let mirror mode override with data byte 0
    always_comb begin
        chk_flip = inj_en ? (chk_in ^ mask_chk) : chk_in;
        chk_out  = mirror_en ? data_out[CHK_W-1:0] : chk_flip;
    end

endmodule

// File: rtl/eccw_decode.sv
// Module eccw_decode
// Read-side SECDED decoder for the {check, data} layout. Reports clean,
// corrected (with the bit repaired if it is a data bit) or uncorrectable.
// Assumes at most the code's guaranteed error weight for correct reporting.
module eccw_decode
    import ecc_inj_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [DATA_W-1:0] data,
    output logic [1:0]        status,
    output logic [CHK_W-1:0]  syndrome
);

    logic [HAM_W-1:0] syn;
    logic             par;
    logic             is_pow2;
    logic             hit_data;
    logic [DATA_W-1:0] flip;

    // Position syndrome: XOR of the positions of every set bit received
    always_comb begin
        syn = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (word[i]) syn = syn ^ data_pos(i);
        end
        for (int k = 0; k < HAM_W; k++) begin
            if (word[DATA_W + k]) syn[k] = ~syn[k];
        end
    end

    // Overall parity across all stored bits
    assign par = ^word;

    // Locate a data bit matching the syndrome
    always_comb begin
        flip     = '0;
        hit_data = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (syn == data_pos(i)) begin
                flip[i]  = 1'b1;
                hit_data = 1'b1;
            end
        end
    end

    assign is_pow2 = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

    // Classify and repair
    always_comb begin
        data = word[DATA_W-1:0];
        if (!par) begin
            status = (syn == '0) ? DEC_CLEAN : DEC_FATAL;
        end else if (syn == '0 || is_pow2) begin
            status = DEC_FIXED;
        end else if (hit_data) begin
            status = DEC_FIXED;
            data   = word[DATA_W-1:0] ^ flip;
        end else begin
            status = DEC_FATAL;
        end
    end

    assign syndrome = {par, syn};

endmodule

// File: rtl/ecc_inject_wpath.sv
// Module ecc_inject_wpath
// Top of the SECDED write path: merge -> encode -> inject -> output register,
// with a combinational decoder beside it for the read side.
// Assumes configuration is stable for the beat it applies to; reset is
// synchronous and active low.
module ecc_inject_wpath
    import ecc_inj_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NBYTES-1:0]    wr_be,
    input  logic [DATA_W-1:0]    rd_merge_data,
    input  logic [HALF_W-1:0]    cfg_mask_hi,
    input  logic [HALF_W-1:0]    cfg_mask_lo,
    input  logic [CHK_W-1:0]     cfg_chk_mask,
    input  logic                 cfg_inj_en,
    input  logic                 cfg_mirror_en,
    output logic                 st_valid,
    output logic [WORD_W-1:0]    st_word,
    input  logic [WORD_W-1:0]    dec_word,
    output logic [DATA_W-1:0]    dec_data,
    output logic [1:0]           dec_status,
    output logic [CHK_W-1:0]     dec_syndrome
);

    logic [DATA_W-1:0] merged;
    logic [CHK_W-1:0]  clean_chk;
    logic [DATA_W-1:0] inj_data;
    logic [CHK_W-1:0]  inj_chk;

    eccw_merge #(.LANES(NBYTES), .LANE_W(BYTE_W)) u_merge (
        .new_data (wr_data),
        .lane_en  (wr_be),
        .old_data (rd_merge_data),
        .merged   (merged)
    );

    eccw_encode u_encode (
        .data (merged),
        .chk  (clean_chk)
    );

    eccw_inject u_inject (
        .data_in   (merged),
        .chk_in    (clean_chk),
        .mask_hi   (cfg_mask_hi),
        .mask_lo   (cfg_mask_lo),
        .mask_chk  (cfg_chk_mask),
        .inj_en    (cfg_inj_en),
        .mirror_en (cfg_mirror_en),
        .data_out  (inj_data),
        .chk_out   (inj_chk)
    );

    // Register the word to store; hold it between beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_word  <= '0;
        end else begin
            st_valid <= wr_valid;
            if (wr_valid) st_word <= {inj_chk, inj_data};
        end
    end

    eccw_decode u_decode (
        .word     (dec_word),
        .data     (dec_data),
        .status   (dec_status),
        .syndrome (dec_syndrome)
    );

endmodule

// File: rtl/eccw_checker.sv
// Module eccw_checker
// Protocol and datapath properties of ecc_inject_wpath, bound to every
// instance of it.
module eccw_checker
    import ecc_inj_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid,
    input logic [DATA_W-1:0]    wr_data,
    input logic [NBYTES-1:0]    wr_be,
    input logic [HALF_W-1:0]    cfg_mask_hi,
    input logic [HALF_W-1:0]    cfg_mask_lo,
    input logic                 cfg_inj_en,
    input logic                 cfg_mirror_en,
    input logic                 st_valid,
    input logic [WORD_W-1:0]    st_word,
    input logic [WORD_W-1:0]    dec_word,
    input logic [DATA_W-1:0]    dec_data,
    input logic [1:0]           dec_status,
    input logic [CHK_W-1:0]     dec_syndrome
);

    // R2
    beat_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> st_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !st_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(st_word));

    // R5
    clean_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !cfg_inj_en && (&wr_be)) |=> (st_word[DATA_W-1:0] == $past(wr_data)));

    // R6
    data_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cfg_inj_en && (&wr_be)) |=>
            (st_word[DATA_W-1:0] == $past(wr_data ^ {cfg_mask_hi, cfg_mask_lo})));

    // R8
    mirror_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cfg_mirror_en) |=> (st_word[WORD_W-1:DATA_W] == st_word[CHK_W-1:0]));

    // R9
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_syndrome == '0) |-> (dec_status == DEC_CLEAN && dec_data == dec_word[DATA_W-1:0]));

    // R11
    even_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_syndrome[CHK_W-1] && dec_syndrome != '0) |-> (dec_status == DEC_FATAL));

    // R10
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_status != 2'b11);

endmodule

bind ecc_inject_wpath eccw_checker u_eccw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_data       (wr_data),
    .wr_be         (wr_be),
    .cfg_mask_hi   (cfg_mask_hi),
    .cfg_mask_lo   (cfg_mask_lo),
    .cfg_inj_en    (cfg_inj_en),
    .cfg_mirror_en (cfg_mirror_en),
    .st_valid      (st_valid),
    .st_word       (st_word),
    .dec_word      (dec_word),
    .dec_data      (dec_data),
    .dec_status    (dec_status),
    .dec_syndrome  (dec_syndrome)
);

// File: tb/ecc_inject_wpath_bench.sv
module ecc_inject_wpath_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_be = '0;
    logic [63:0] rd_merge_data = '0;
    logic [31:0] cfg_mask_hi = '0;
    logic [31:0] cfg_mask_lo = '0;
    logic [7:0]  cfg_chk_mask = '0;
    logic        cfg_inj_en = 1'b0;
    logic        cfg_mirror_en = 1'b0;
    logic        st_valid;
    logic [71:0] st_word;
    logic [71:0] dec_word = '0;
    logic [63:0] dec_data;
    logic [1:0]  dec_status;
    logic [7:0]  dec_syndrome;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int bpos[64];
    logic [71:0] last_word = '0;

    always #2 clk = ~clk;

    ecc_inject_wpath u_ecc_inject_wpath (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_be(wr_be), .rd_merge_data(rd_merge_data), .cfg_mask_hi(cfg_mask_hi),
        .cfg_mask_lo(cfg_mask_lo), .cfg_chk_mask(cfg_chk_mask), .cfg_inj_en(cfg_inj_en),
        .cfg_mirror_en(cfg_mirror_en), .st_valid(st_valid), .st_word(st_word),
        .dec_word(dec_word), .dec_data(dec_data), .dec_status(dec_status),
        .dec_syndrome(dec_syndrome)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_code(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int k = 0; k < 7; k++)
            for (int i = 0; i < 64; i++)
                if (bpos[i][k]) c[k] = c[k] ^ d[i];
        c[7] = (^d) ^ (^c[6:0]);
        return c;
    endfunction

    function automatic int idx_of(input int pos);
        for (int i = 0; i < 64; i++) if (bpos[i] == pos) return i;
        return -1;
    endfunction

    // Drive one beat, then compare the stored word one edge later
    task automatic beat(input logic [63:0] d, input logic [7:0] be, input logic [63:0] old,
                        input logic [31:0] hi, input logic [31:0] lo, input logic [7:0] cm,
                        input bit inj, input bit mir, input string req);
        logic [63:0] m, sd;
        logic [7:0]  sc;
        for (int b = 0; b < 8; b++) m[b*8 +: 8] = be[b] ? d[b*8 +: 8] : old[b*8 +: 8];
        sd = inj ? (m ^ {hi, lo}) : m;
        sc = inj ? (ref_code(m) ^ cm) : ref_code(m);
        if (mir) sc = sd[7:0];
        wr_valid = 1'b1; wr_data = d; wr_be = be; rd_merge_data = old;
        cfg_mask_hi = hi; cfg_mask_lo = lo; cfg_chk_mask = cm;
        cfg_inj_en = inj; cfg_mirror_en = mir;
        @(posedge clk); #1;
        wr_valid = 1'b0;
        last_word = {sc, sd};
        check(st_valid === 1'b1 && st_word === last_word, req, {55'd0, st_valid, st_word}, {56'd1, last_word});
    endtask

    // One idle edge: output must be quiet and held
    task automatic idle(input string req);
        @(posedge clk); #1;
        check(st_valid === 1'b0 && st_word === last_word, req, {55'd0, st_valid, st_word}, {56'd0, last_word});
    endtask

    task automatic dec_chk(input logic [71:0] w, input logic [1:0] est, input logic [7:0] esyn,
                           input logic [63:0] edata, input string req);
        dec_word = w;
        #1;
        check(dec_status === est && dec_syndrome === esyn && dec_data === edata, req,
              {54'd0, dec_status, dec_syndrome, dec_data}, {54'd0, est, esyn, edata});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] d0, d1;
        logic [71:0] w;
        int n = 0;
        for (int p = 3; n < 64; p++) if ($countones(p) != 1) begin bpos[n] = p; n++; end
        d0 = 64'h0123_4567_89AB_CDEF;
        d1 = 64'hFEDC_BA98_7654_3210;

        // R1: reset clears the output
        wr_valid = 1'b1; wr_data = d0; wr_be = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check(st_valid === 1'b0 && st_word === 72'd0, "R1", {55'd0, st_valid, st_word}, 128'd0);
        wr_valid = 1'b0;
        rst_n = 1'b1;
        idle("R1");

        // R3, R5: clean full writes
        beat(d0, 8'hFF, '0, '0, '0, '0, 1'b0, 1'b0, "R3");
        idle("R2");
        beat(64'd1, 8'hFF, '0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 1'b0, 1'b0, "R5");
        beat(64'h8000_0000_0000_0000, 8'hFF, '0, '0, '0, '0, 1'b0, 1'b0, "R3");
        beat('0, 8'hFF, '1, '0, '0, '0, 1'b0, 1'b0, "R3");
        // R2: back-to-back beats, then hold
        beat(d1, 8'hFF, '0, '0, '0, '0, 1'b0, 1'b0, "R2");
        idle("R2");
        idle("R2");

        // R4: partial merges
        beat(d1, 8'h0F, d0, '0, '0, '0, 1'b0, 1'b0, "R4");
        beat(d1, 8'hA5, d0, '0, '0, '0, 1'b0, 1'b0, "R4");
        beat(d1, 8'h00, d0, '0, '0, '0, 1'b0, 1'b0, "R4");

        // R6: data masks, high and low halves
        beat(d0, 8'hFF, '0, 32'h8000_0001, 32'h0000_0000, '0, 1'b1, 1'b0, "R6");
        beat(d0, 8'hFF, '0, 32'h0000_0000, 32'h0000_0100, '0, 1'b1, 1'b0, "R6");
        // R7: check masks at both extremes
        beat(d1, 8'hFF, '0, '0, '0, 8'hFF, 1'b1, 1'b0, "R7");
        beat(d1, 8'hFF, '0, '0, '0, 8'h00, 1'b1, 1'b0, "R7");
        beat(d1, 8'hFF, '0, '0, '0, 8'h81, 1'b1, 1'b0, "R7");

        // R4 with R6: partial beat with armed injection over merged and new bytes
        beat(d1, 8'hF0, d0, 32'h0000_0010, 32'h0100_0000, 8'h04, 1'b1, 1'b0, "R4");

        // R8: mirror with and without injection; check mask must not matter
        beat(d0, 8'hFF, '0, '0, '0, 8'h5A, 1'b0, 1'b1, "R8");
        beat(d0, 8'hFF, '0, '0, 32'h0000_00C3, 8'h5A, 1'b1, 1'b1, "R8");
        beat(d1, 8'h01, d0, '0, 32'h0000_0001, 8'hFF, 1'b1, 1'b1, "R8");

        // R5: repair write after a corrupted one
        beat(d0, 8'hFF, '0, '1, '1, 8'hFF, 1'b1, 1'b0, "R6");
        beat(d0, 8'hFF, '0, '1, '1, 8'hFF, 1'b0, 1'b0, "R5");
        idle("R2");

        // Decoder checks, words built from the bench's own encoder
        w = {ref_code(d0), d0};
        dec_chk(w, 2'b00, 8'h00, d0, "R9");
        dec_chk({ref_code('0), 64'd0}, 2'b00, 8'h00, 64'd0, "R9");
        dec_chk(w ^ (72'd1 << 0), 2'b01, {1'b1, 7'(bpos[0])}, d0, "R10");
        dec_chk(w ^ (72'd1 << 63), 2'b01, {1'b1, 7'(bpos[63])}, d0, "R10");
        dec_chk(w ^ (72'd1 << 37), 2'b01, {1'b1, 7'(bpos[37])}, d0, "R10");
        dec_chk(w ^ (72'd1 << 66), 2'b01, 8'h84, d0, "R10");
        dec_chk(w ^ (72'd1 << 71), 2'b01, 8'h80, d0, "R10");
        dec_chk(w ^ (72'd1 << 5) ^ (72'd1 << 40), 2'b10,
                {1'b0, 7'(bpos[5] ^ bpos[40])}, d0 ^ (64'd1 << 5) ^ (64'd1 << 40), "R11");
        dec_chk(w ^ (72'd1 << 70) ^ (72'd1 << 69) ^ (72'd1 << idx_of(31)), 2'b10, 8'hFF,
                d0 ^ (64'd1 << idx_of(31)), "R11");

        // Round trip: injected stored words through the decoder
        beat(d1, 8'hFF, '0, 32'h0000_0400, '0, '0, 1'b1, 1'b0, "R6");
        dec_chk(st_word, 2'b01, {1'b1, 7'(bpos[42])}, d1, "R10");
        beat(d1, 8'hFF, '0, '0, '0, 8'h02, 1'b1, 1'b0, "R7");
        dec_chk(st_word, 2'b01, 8'h82, d1, "R10");
        beat(d1, 8'hFF, '0, '0, 32'h0000_0003, '0, 1'b1, 1'b0, "R6");
        dec_chk(st_word, 2'b10, {1'b0, 7'(bpos[0] ^ bpos[1])}, d1 ^ 64'd3, "R11");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule